// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of a SPI shift engine from the system clock. A programmable divider sets the serial clock rate. A law-select bit chooses how that divider value is read: as a power-of-two exponent or as a linear count. The block drives a serial-clock level and two single-cycle strobes, one for the leading (rising) edge and one for the trailing (falling) edge. The shift engine uses the strobes to sample and launch data. Polarity and phase are the shift engine's job and are not handled here.

The shift engine holds `run` high for the length of a transfer. While `run` is low the divider is held cleared. The divider value and the law bit are captured when `run` rises, so reprogramming them during a transfer changes nothing until the next start.

Top module: `sclk_divider`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sclk`, `lead_stb` and `trail_stb` are all 0.
- R2: With `div_mode` = 0 the serial clock half-period is 2^N system cycles, where N = `div_val[3:0]`, so the full period is 2^(N+1) cycles.
- R3: With `div_mode` = 0, bits 7:4 of `div_val` are ignored. For example, 8'hF2 gives the same half-period as 8'h02, which is 4 cycles.
- R4: With `div_mode` = 1 the half-period is N+1 system cycles for N = `div_val` from 0 to 255, so the full period is 2*(N+1) cycles.
- R5: While `run` is low, `sclk` is 0 and no strobe is issued. If `run` is first sampled high at a rising clock edge, the first leading strobe and the rise of `sclk` appear exactly one half-period of cycles after that edge.
- R6: Each strobe is one system cycle wide. The two strobes are never high together. They alternate, and the first one after a start is the leading strobe.
- R7: In the cycle `lead_stb` is high, `sclk` has just risen to 1. In the cycle `trail_stb` is high, `sclk` has just fallen to 0.
- R8: A change to `div_val` or `div_mode` while `run` is high does not alter the running period. The new setting takes effect at the next rise of `run`.
- R9: The smallest setting (half-period 1, from N = 0 in either law) issues a strobe on every system cycle. The edge rate then equals the system clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | High while the shift engine is transferring |
| div_val | input | 8 | Divider value N |
| div_mode | input | 1 | Law select: 0 = power-of-two, 1 = linear |
| sclk | output | 1 | Serial clock level, idle low |
| lead_stb | output | 1 | One-cycle strobe on each rising serial clock edge |
| trail_stb | output | 1 | One-cycle strobe on each falling serial clock edge |

## Verification
The stimulus table covers both laws at their smallest, middle and largest values. In the power-of-two law it includes a value with junk in the high nibble, which shows whether the exponent is masked or read in full. Each vector measures the start latency and two later edge gaps on their own, so a divider that is off by one cycle or that misplaces the first edge is caught. Directed tests then reprogram the divider mid-transfer to separate latching at start from live use, stop a transfer with `sclk` high to check the idle return, and run at half-period 1 to check strobes on every cycle.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

   typedef enum logic {
      LAW_POW2   = 1'b0,
      LAW_LINEAR = 1'b1
   } div_law_e;

   typedef struct packed {
      logic lead;
      logic trail;
   } edge_stb_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Width of the terminal-count value for both laws
   function automatic int term_width(input int div_w, input int pow_w);
      return imax((2 ** pow_w) - 1, div_w);
   endfunction

endpackage

// File: rtl/sclk_div_law.sv
module sclk_div_law
   import sclk_div_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int POW_W  = 4,
   parameter int TERM_W = term_width(DIV_W, POW_W)
) (
   input  logic [DIV_W-1:0]  div_val,
   input  div_law_e          law,
   output logic [TERM_W-1:0] term
);

   localparam int POW_TERMS = (2 ** POW_W) - 1;

   logic [POW_W-1:0]  expo;
   logic [TERM_W-1:0] pow_term;
   logic [TERM_W-1:0] lin_term;

   assign expo = div_val[POW_W-1:0];

   // Power-of-two law: terminal count 2^N - 1 as a thermometer mask
   for (genvar b = 0; b < TERM_W; b++) begin : g_thermo
      if (b < POW_TERMS) begin : g_live
         assign pow_term[b] = (int'(expo) > b);
      end else begin : g_zero
         assign pow_term[b] = 1'b0;
      end
   end

   // Linear law: terminal count N
   if (TERM_W > DIV_W) begin : g_lin_ext
      assign lin_term = {{(TERM_W-DIV_W){1'b0}}, div_val};
   end else begin : g_lin_fit
      assign lin_term = div_val;
   end

   always_comb begin
      unique case (law)
         LAW_POW2:   term = pow_term;
         LAW_LINEAR: term = lin_term;
         default:    term = pow_term;
      endcase
   end

endmodule

// File: rtl/sclk_div_timer.sv
module sclk_div_timer #(
   parameter int TERM_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [TERM_W-1:0] term_in,
   output logic              tick
);

   logic              active_q;
   logic [TERM_W-1:0] term_q;
   logic [TERM_W-1:0] cnt_q;

   assign tick = run && active_q && (cnt_q == term_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         term_q   <= '0;
         cnt_q    <= '0;
      end else if (!run) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (!active_q) begin
         active_q <= 1'b1;
         term_q   <= term_in;
         cnt_q    <= '0;
      end else if (tick) begin
         cnt_q    <= '0;
      end else begin
         cnt_q    <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen
   import sclk_div_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   input  logic      tick,
   output logic      level,
   output edge_stb_t stb
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= 1'b0;
         stb   <= '0;
      end else if (!run) begin
         level <= 1'b0;
         stb   <= '0;
      end else begin
         stb.lead  <= tick && !level;
         stb.trail <= tick && level;
         if (tick) level <= ~level;
      end
   end

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
   import sclk_div_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int POW_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_val,
   input  logic             div_mode,
   output logic             sclk,
   output logic             lead_stb,
   output logic             trail_stb
);

   localparam int TERM_W = term_width(DIV_W, POW_W);

   if (POW_W < 1 || POW_W > 5) begin : g_bad_pow
      $error("sclk_divider: POW_W out of range");
   end
   if (DIV_W < POW_W) begin : g_bad_div
      $error("sclk_divider: DIV_W narrower than POW_W");
   end

   logic [TERM_W-1:0] term;
   logic              tick;
   edge_stb_t         stb;
   div_law_e          law;

   assign law = div_law_e'(div_mode);

   sclk_div_law #(
      .DIV_W (DIV_W),
      .POW_W (POW_W),
      .TERM_W(TERM_W)
   ) law_i (
      .div_val(div_val),
      .law    (law),
      .term   (term)
   );

   sclk_div_timer #(
      .TERM_W(TERM_W)
   ) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .term_in(term),
      .tick   (tick)
   );

   sclk_edge_gen edge_i (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .tick (tick),
      .level(sclk),
      .stb  (stb)
   );

   assign lead_stb  = stb.lead;
   assign trail_stb = stb.trail;

endmodule

// File: rtl/sclk_divider_chk.sv
module sclk_divider_chk (
   input logic clk,
   input logic rst_n,
   input logic run,
   input logic sclk,
   input logic lead_stb,
   input logic trail_stb
);

   assert_no_dual_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_stb && trail_stb));

   assert_lead_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lead_stb |=> !lead_stb);

   assert_trail_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trail_stb |=> !trail_stb);

   assert_lead_marks_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lead_stb |-> (sclk && !$past(sclk)));

   assert_trail_marks_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trail_stb |-> (!sclk && $past(sclk)));

   assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run) |-> (!sclk && !lead_stb && !trail_stb));

endmodule

bind sclk_divider sclk_divider_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .sclk     (sclk),
   .lead_stb (lead_stb),
   .trail_stb(trail_stb)
);

// File: tb/sclk_divider_tb_top.sv
`timescale 1ns/1ps
module sclk_divider_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic [7:0] div_val = '0;
   logic       div_mode = 1'b0;
   logic       sclk, lead_stb, trail_stb;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   sclk_divider dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .div_val  (div_val),
      .div_mode (div_mode),
      .sclk     (sclk),
      .lead_stb (lead_stb),
      .trail_stb(trail_stb)
   );

   // Vectors: law bit, divider value, expected half-period
   localparam int NV = 9;
   localparam int V_MODE [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1};
   localparam int V_N    [NV] = '{0, 3, 8'hF2, 7, 15, 0, 9, 100, 255};
   localparam int V_HALF [NV] = '{1, 8, 4, 128, 32768, 1, 10, 101, 256};
   localparam int LIMIT = 70000;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Wait for a strobe; returns number of samples taken and whether
   // anything unexpected was seen (wrong strobe, both strobes).
   task automatic wait_stb(input bit want_lead, output int cnt, output bit bad);
      bit got = 1'b0;
      cnt = 0;
      bad = 1'b0;
      while (!got && cnt < LIMIT) begin
         @(negedge clk);
         cnt++;
         if (lead_stb && trail_stb) bad = 1'b1;
         if (want_lead && trail_stb) bad = 1'b1;
         if (!want_lead && lead_stb) bad = 1'b1;
         got = want_lead ? lead_stb : trail_stb;
      end
   endtask

   // run was raised before the next posedge; measure latency and gaps
   task automatic measure(input int half, input string req);
      int c;
      bit bad;
      bit lvl_ok;
      wait_stb(1'b1, c, bad);
      check(c == half + 1 && !bad, {req, " R5 first lead latency"}, c, half + 1);
      lvl_ok = (sclk == 1'b1);
      wait_stb(1'b0, c, bad);
      check(c == half && !bad, {req, " trail gap"}, c, half);
      check(lvl_ok && sclk == 1'b0, "R7 level at strobes", int'(sclk), 0);
      wait_stb(1'b1, c, bad);
      check(c == half && !bad && sclk, {req, " R6 lead gap"}, c, half);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int c;
      bit bad;
      // R1: reset state
      @(negedge clk);
      check(!sclk && !lead_stb && !trail_stb, "R1 in reset", int'(sclk), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!sclk && !lead_stb && !trail_stb, "R1 after reset", int'(sclk), 0);

      // Table walk: R2, R3, R4, R9
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         run      = 1'b0;
         div_mode = V_MODE[i][0];
         div_val  = V_N[i][7:0];
         @(negedge clk);
         run = 1'b1;
         if (V_MODE[i] == 1)             measure(V_HALF[i], "R4");
         else if (V_N[i] > 15)           measure(V_HALF[i], "R3");
         else                            measure(V_HALF[i], "R2");
      end

      // R5: stop with sclk high, output must drop and stay quiet
      @(negedge clk);
      check(sclk == 1'b1, "R5 sclk high before stop", int'(sclk), 1);
      run = 1'b0;
      bad = 1'b0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (sclk || lead_stb || trail_stb) bad = 1'b1;
      end
      check(!bad, "R5 idle quiet", int'(bad), 0);

      // R9: half-period 1, strobe on every cycle, alternating
      div_mode = 1'b1;
      div_val  = 8'd0;
      @(negedge clk);
      run = 1'b1;
      @(negedge clk);
      bad = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if ((k % 2) == 0 && !(lead_stb && !trail_stb && sclk)) bad = 1'b1;
         if ((k % 2) == 1 && !(trail_stb && !lead_stb && !sclk)) bad = 1'b1;
      end
      check(!bad, "R9 strobe every cycle", int'(bad), 0);

      // R8: reprogram mid-run, old period held until restart
      @(negedge clk);
      run      = 1'b0;
      div_mode = 1'b1;
      div_val  = 8'd3;
      @(negedge clk);
      run = 1'b1;
      @(negedge clk);
      div_mode = 1'b0;
      div_val  = 8'd20;
      wait_stb(1'b1, c, bad);
      check(c == 4 && !bad, "R8 first lead with old setting", c, 4);
      wait_stb(1'b0, c, bad);
      check(c == 4 && !bad, "R8 trail gap unchanged", c, 4);
      wait_stb(1'b1, c, bad);
      check(c == 4 && !bad, "R8 lead gap unchanged", c, 4);
      @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      run = 1'b1;
      measure(16, "R8 new setting after restart");

      @(negedge clk);
      run = 1'b0;
      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule